// File: doc/BRIEF.md
# DDS Tuning Word Calculator

This block keeps the output frequency of a direct digital synthesizer as a 32-bit hertz value and converts it into the phase-increment tuning word that the synthesizer needs. Single-cycle request pulses move the frequency up or down by a fixed step. A level input for the transmit state shifts the frequency by a fixed offset while that input is high. Two further pulses trim the reference constant used in the conversion. Results are kept inside a band that has separate upper and lower edges.

Each accepted request starts a serial multiply. The frequency is multiplied by a reference constant in 8.24 fixed point, one multiplier bit per cycle, over 32 cycles. The result is presented as a 40-bit control word with a one-cycle done strobe. Requests that arrive while a conversion runs are held and served one at a time after it completes. Storing the frequency, reading the knob and serialising the control word are handled by neighbouring blocks.

Top module: `dds_word_calc`

## Requirements
- R1: During and after reset, freq_hz is 7,030,000 (parameter RESET_FREQ), busy and word_done are low, and the reference constant is 0x225C17D0. One conversion runs on its own after reset is released.
- R2: When word_done is high, ctl_word[31:0] equals bits 55:24 of the 64-bit product freq_hz × reference constant, taken at the frequency and constant that the conversion used.
- R3: ctl_word[39:32] is 0x00 when parameter X6_REF is 0, and 0x01 when X6_REF is 1.
- R4: A step_up pulse adds STEP (10) to the frequency. If the sum is above UPPER, the frequency becomes UPPER. A sum equal to UPPER is kept.
- R5: A step_dn pulse subtracts STEP. If the 32-bit difference has bit 31 set, or is below LOWER, the frequency becomes LOWER.
- R6: When tx_key goes high, the frequency drops by TX_OFS (0x200) exactly once. When tx_key goes low, the frequency rises by TX_OFS exactly once. Neither move is clamped. Holding tx_key at a steady level causes no further change and no further conversion.
- R7: A cal_up pulse adds CAL_STEP (0x10) to the reference constant. A cal_dn pulse subtracts CAL_STEP. The frequency is left unchanged, and a fresh conversion uses the new constant.
- R8: For each conversion, busy is high for exactly 32 consecutive cycles. word_done is a one-cycle pulse in the cycle right after busy falls.
- R9: freq_hz does not change while busy is high. Requests that arrive during a conversion are held and applied after it completes, one conversion for each request.
- R10: When several requests are pending at once, one is served per conversion, in this order: transmit change, cal_up, cal_dn, step_up, step_dn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_up | input | 1 | Pulse: raise the frequency by one step |
| step_dn | input | 1 | Pulse: lower the frequency by one step |
| tx_key | input | 1 | Level: transmit state, applies the offset |
| cal_up | input | 1 | Pulse: raise the reference constant |
| cal_dn | input | 1 | Pulse: lower the reference constant |
| freq_hz | output | 32 | Current frequency in hertz |
| ctl_word | output | 40 | Control byte and tuning word |
| word_done | output | 1 | One-cycle strobe when ctl_word is updated |
| busy | output | 1 | Serial multiply in progress |

## Verification
A bad accumulator, multiplicand or iteration count does not show on freq_hz. It shows as a wrong ctl_word at the next word_done, which comes 34 cycles after the request that started the conversion. A lost or duplicated pending request shows as a missing or extra word_done, or as a final frequency one step away from the expected value, within two conversions. A stale transmit flag shows as a second offset, or as a missing one, on the next tx_key edge. The clamp and priority cases are each checked against a model of frequency and constant that the bench keeps independently.

// File: rtl/dds_word_pkg.sv
package dds_word_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_REFRESH,
    ACT_TX,
    ACT_CAL_UP,
    ACT_CAL_DN,
    ACT_UP,
    ACT_DN
  } dds_act_e;

  localparam logic [7:0] CTRL_BYTE_DIRECT = 8'h00;
  localparam logic [7:0] CTRL_BYTE_X6     = 8'h01;
endpackage

// File: rtl/dds_tune_state.sv
module dds_tune_state
  import dds_word_pkg::*;
#(
  parameter int          W          = 32,
  parameter int unsigned RESET_FREQ = 7030000,
  parameter int unsigned UPPER      = 7200000,
  parameter int unsigned LOWER      = 7000000,
  parameter int unsigned STEP       = 10,
  parameter int unsigned TX_OFS     = 32'h200,
  parameter int unsigned K_INIT     = 32'h225C17D0,
  parameter int unsigned CAL_STEP   = 32'h10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_up,
  input  logic         req_dn,
  input  logic         req_cu,
  input  logic         req_cd,
  input  logic         tx_key,
  input  logic         hold,
  output logic [W-1:0] freq_q,
  output logic [W-1:0] kref_q,
  output logic         go
);
  localparam logic [W-1:0] STEP_V  = W'(STEP);
  localparam logic [W-1:0] UPPER_V = W'(UPPER);
  localparam logic [W-1:0] LOWER_V = W'(LOWER);
  localparam logic [W-1:0] TXO_V   = W'(TX_OFS);
  localparam logic [W-1:0] CAL_V   = W'(CAL_STEP);

  logic     pend_up, pend_dn, pend_cu, pend_cd, pend_init, tx_on;
  dds_act_e act;
  logic [W-1:0] freq_d, kref_d, sum_up, dif_dn;

  assign sum_up = freq_q + STEP_V;
  assign dif_dn = freq_q - STEP_V;

  always_comb begin
    act = ACT_NONE;
    if (!hold) begin
      if (tx_key != tx_on) act = ACT_TX;
      else if (pend_cu)    act = ACT_CAL_UP;
      else if (pend_cd)    act = ACT_CAL_DN;
      else if (pend_up)    act = ACT_UP;
      else if (pend_dn)    act = ACT_DN;
      else if (pend_init)  act = ACT_REFRESH;
    end
  end

  always_comb begin
    freq_d = freq_q;
    kref_d = kref_q;
    case (act)
      ACT_TX:     freq_d = tx_key ? (freq_q - TXO_V) : (freq_q + TXO_V);
      ACT_CAL_UP: kref_d = kref_q + CAL_V;
      ACT_CAL_DN: kref_d = kref_q - CAL_V;
      ACT_UP:     freq_d = (sum_up > UPPER_V) ? UPPER_V : sum_up;
      ACT_DN:     freq_d = (dif_dn[W-1] || (dif_dn < LOWER_V)) ? LOWER_V : dif_dn;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q    <= W'(RESET_FREQ);
      kref_q    <= W'(K_INIT);
      tx_on     <= 1'b0;
      pend_up   <= 1'b0;
      pend_dn   <= 1'b0;
      pend_cu   <= 1'b0;
      pend_cd   <= 1'b0;
      pend_init <= 1'b1;
      go        <= 1'b0;
    end else begin
      freq_q    <= freq_d;
      kref_q    <= kref_d;
      go        <= (act != ACT_NONE);
      if (act == ACT_TX) tx_on <= tx_key;
      pend_up   <= (pend_up && (act != ACT_UP))     || req_up;
      pend_dn   <= (pend_dn && (act != ACT_DN))     || req_dn;
      pend_cu   <= (pend_cu && (act != ACT_CAL_UP)) || req_cu;
      pend_cd   <= (pend_cd && (act != ACT_CAL_DN)) || req_cd;
      pend_init <= pend_init && (act == ACT_NONE);
    end
  end
endmodule

// File: rtl/dds_serial_mul.sv
module dds_serial_mul #(
  parameter int W    = 32,
  parameter int FRAC = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int OFS   = W - FRAC;
  localparam int ACC_W = W + OFS;
  localparam int CW    = $clog2(W);

  logic [ACC_W-1:0] acc, addend;
  logic [ACC_W:0]   sum;
  logic [W-1:0]     mc, mp;
  logic [CW-1:0]    cnt;

  assign addend = mp[0] ? {mc, {OFS{1'b0}}} : '0;
  assign sum    = {1'b0, acc} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      mc   <= '0;
      mp   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc  <= '0;
        mc   <= mcand;
        mp   <= mplier;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= sum[ACC_W:1];
        mp  <= mp >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          word <= sum[W:1];
        end
      end
    end
  end
endmodule

// File: rtl/dds_word_calc.sv
module dds_word_calc
  import dds_word_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          FRAC       = 24,
  parameter int unsigned RESET_FREQ = 7030000,
  parameter int unsigned UPPER      = 7200000,
  parameter int unsigned LOWER      = 7000000,
  parameter int unsigned STEP       = 10,
  parameter int unsigned TX_OFS     = 32'h200,
  parameter int unsigned K_INIT     = 32'h225C17D0,
  parameter int unsigned CAL_STEP   = 32'h10,
  parameter bit          X6_REF     = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         tx_key,
  input  logic         cal_up,
  input  logic         cal_dn,
  output logic [31:0]  freq_hz,
  output logic [39:0]  ctl_word,
  output logic         word_done,
  output logic         busy
);
  localparam logic [7:0] CTRL = X6_REF ? CTRL_BYTE_X6 : CTRL_BYTE_DIRECT;

  logic [W-1:0] freq_q, kref_q, word;
  logic         go, mul_busy, mul_done;

  dds_tune_state #(
    .W(W), .RESET_FREQ(RESET_FREQ), .UPPER(UPPER), .LOWER(LOWER),
    .STEP(STEP), .TX_OFS(TX_OFS), .K_INIT(K_INIT), .CAL_STEP(CAL_STEP)
  ) u_state (
    .clk(clk), .rst(rst),
    .req_up(step_up), .req_dn(step_dn), .req_cu(cal_up), .req_cd(cal_dn),
    .tx_key(tx_key), .hold(mul_busy | go),
    .freq_q(freq_q), .kref_q(kref_q), .go(go)
  );

  dds_serial_mul #(.W(W), .FRAC(FRAC)) u_mul (
    .clk(clk), .rst(rst), .go(go),
    .mcand(freq_q), .mplier(kref_q),
    .busy(mul_busy), .done(mul_done), .word(word)
  );

  assign freq_hz   = 32'(freq_q);
  assign ctl_word  = {CTRL, 32'(word)};
  assign word_done = mul_done;
  assign busy      = mul_busy;
endmodule

// File: rtl/dds_word_calc_chk.sv
module dds_word_calc_chk #(
  parameter bit X6_REF = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        word_done,
  input logic [31:0] freq_hz,
  input logic [39:0] ctl_word
);
  logic [6:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else     busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 7'd32));

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> word_done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    word_done |-> !busy);

  a_r9_freq_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(freq_hz));

  a_r3_ctrl_byte: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (ctl_word[39:32] == (X6_REF ? 8'h01 : 8'h00)));
endmodule

bind dds_word_calc dds_word_calc_chk #(.X6_REF(X6_REF)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .word_done(word_done),
  .freq_hz(freq_hz), .ctl_word(ctl_word)
);

// File: tb/test_dds_word_calc.sv
module test_dds_word_calc;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // op codes: 0 step_up, 1 step_dn, 2 cal_up, 3 cal_dn
  localparam int OPS  [NVEC] = '{0, 0, 1, 2, 3, 3, 2, 1};
  localparam int EXPF [NVEC] = '{7030010, 7030020, 7030010, 7030010,
                                 7030010, 7030010, 7030010, 7030000};

  logic clk = 1'b0, rst = 1'b1;
  logic step_up = 0, step_dn = 0, tx_key = 0, cal_up = 0, cal_dn = 0;
  logic b_dn = 0;
  logic [31:0] freq_hz, b_freq;
  logic [39:0] ctl_word, b_word;
  logic word_done, busy, b_done, b_busy;

  int tests = 0, fails = 0, cyc = 0, busy_seen = 0;
  logic [31:0] k_model = 32'h225C17D0;
  logic [31:0] f_model = 32'd7030000;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_calc #(.UPPER(7030030), .LOWER(7029990)) i_dds_word_calc (
    .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
    .tx_key(tx_key), .cal_up(cal_up), .cal_dn(cal_dn),
    .freq_hz(freq_hz), .ctl_word(ctl_word), .word_done(word_done), .busy(busy));

  dds_word_calc #(.RESET_FREQ(5), .UPPER(100), .LOWER(0), .X6_REF(1'b1)) i_dds_word_calc_b (
    .clk(clk), .rst(rst), .step_up(1'b0), .step_dn(b_dn),
    .tx_key(1'b0), .cal_up(1'b0), .cal_dn(1'b0),
    .freq_hz(b_freq), .ctl_word(b_word), .word_done(b_done), .busy(b_busy));

  function automatic logic [31:0] exp_word(input logic [31:0] f, input logic [31:0] k);
    logic [63:0] p;
    p = 64'(f) * 64'(k);
    return p[55:24];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    busy_seen = 0;
    do begin
      @(negedge clk);
      if (busy) busy_seen++;
      n++;
    end while (!word_done && n < 200);
    check({req, " done seen"}, 64'(word_done), 64'd1);
  endtask

  task automatic check_word(input string req);
    check({req, " freq"}, 64'(freq_hz), 64'(f_model));
    check({req, " word"}, 64'(ctl_word), {24'd0, 8'h00, exp_word(f_model, k_model)});
  endtask

  task automatic pulse(input int op);
    @(negedge clk);
    case (op)
      0: step_up = 1; 1: step_dn = 1; 2: cal_up = 1; default: cal_dn = 1;
    endcase
    @(negedge clk);
    step_up = 0; step_dn = 0; cal_up = 0; cal_dn = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      fails++; tests++;
      $display("FAIL watchdog R8: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset freq", 64'(freq_hz), 64'd7030000);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset done", 64'(word_done), 64'd0);
    rst = 0;
    wait_done("R1 initial");
    check_word("R1 R2 initial");
    // R3 variant byte on second instance, sampled in the same cycle
    check("R3 x6 ctrl", 64'(b_word), {24'd0, 8'h01, exp_word(32'd5, 32'h225C17D0)});
    check("R8 busy length", 64'(busy_seen), 64'd32);
    @(negedge clk);
    check("R8 done one cycle", 64'(word_done), 64'd0);

    // table of vectors: R2 R4 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      pulse(OPS[i]);
      if (OPS[i] == 2) k_model = k_model + 32'h10;
      if (OPS[i] == 3) k_model = k_model - 32'h10;
      f_model = 32'(EXPF[i]);
      wait_done("R7 R2 table");
      check_word("R4 R5 R7 table");
    end

    // R4 upper clamp
    for (int i = 0; i < 4; i++) begin
      pulse(0);
      wait_done("R4 up");
      f_model = (i == 3) ? 32'd7030030 : 32'(7030010 + 10 * i);
      check_word("R4 clamp up");
    end
    // R5 lower clamp
    for (int i = 0; i < 5; i++) begin
      pulse(1);
      wait_done("R5 dn");
      f_model = (i >= 3) ? 32'd7029990 : 32'(7030020 - 10 * i);
      check_word("R5 clamp dn");
    end

    // R6 transmit offset
    @(negedge clk); tx_key = 1;
    wait_done("R6 key");
    f_model = 32'd7029478;
    check_word("R6 offset down");
    begin
      int extra = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (word_done || freq_hz != 32'd7029478) extra++;
      end
      check("R6 held no repeat", 64'(extra), 64'd0);
    end
    tx_key = 0;
    wait_done("R6 release");
    f_model = 32'd7029990;
    check_word("R6 offset up");

    // R9 request held while busy
    pulse(0);
    while (!busy) @(negedge clk);
    pulse(1);
    check("R9 freq frozen", 64'(freq_hz), 64'd7030000);
    wait_done("R9 first");
    f_model = 32'd7030000;
    check_word("R9 first");
    wait_done("R9 held");
    f_model = 32'd7029990;
    check_word("R9 held applied");

    // R10 priority: cal_dn before step_up
    @(negedge clk); step_up = 1; cal_dn = 1;
    @(negedge clk); step_up = 0; cal_dn = 0;
    wait_done("R10 first");
    k_model = k_model - 32'h10;
    check_word("R10 cal first");
    wait_done("R10 second");
    f_model = 32'd7030000;
    check_word("R10 step second");

    // R5 wrap below zero on second instance
    @(negedge clk); b_dn = 1;
    @(negedge clk); b_dn = 0;
    begin
      int n = 0;
      while (!b_done && n < 200) begin @(negedge clk); n++; end
    end
    check("R5 wrap to lower", 64'(b_freq), 64'd0);
    check("R3 R5 wrap word", 64'(b_word), {24'd0, 8'h01, 32'd0});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule